// File: doc/BRIEF.md
# Pipelined Signed Array Multiply-Add

This block computes `a*x + y` on two's-complement operands. `a` and `x` are `N` bits wide and `y` is a `2N`-bit signed addend. The result is `2N` bits wide and wraps modulo `2^(2N)`. The core is a regular grid of `N` carry-save rows. Each row has one cell per result column, and each cell pairs the AND gate that forms its partial-product bit with a full adder.

The addend does not need a separate adder stage. It enters as one of the two redundant operands of the first row, in the place that would otherwise hold zero. Signed operands are handled by inverting the partial-product bits that involve exactly one of the two sign bits. Two constant ones, at bit `N` and bit `2N-1`, go in through the other redundant operand of the first row.

The redundant pair from the last row feeds a ripple carry-propagate adder, and a registered output stage follows it. A parameter chooses between two builds. One is fully combinational through the array. The other places a register after every carry-save row. A valid flag travels with each operand set. Every register stage loads only when its valid flag is set.

Top module: `fma_array_mac`

## Requirements
- R1: For every accepted operand set, `out_result` equals `(signed(in_a) * signed(in_x) + signed(in_y)) mod 2^(2N)`. `in_a` and `in_x` are read as N-bit two's complement and `in_y` as 2N-bit two's complement.
- R2: The result is correct when either or both multiplier operands take the most negative value `-2^(N-1)`. This includes the product `(-2^(N-1))^2 = 2^(2N-2)`.
- R3: When the true sum falls outside the signed 2N-bit range, the result wraps modulo `2^(2N)` and nothing else is signalled. For example, `y = 2^(2N-1)-1` plus a product of 1 gives bit pattern `2^(2N-1)`.
- R4: `out_valid` repeats `in_valid` exactly `LAT` cycles later. With `PIPELINE=1`, `LAT = N+1`. With `PIPELINE=0`, `LAT = 1`. The result for an operand set appears in the same cycle as its `out_valid`.
- R5: A new operand set can be accepted in every cycle. Back-to-back sets each produce their own result, in order, one per cycle.
- R6: In a cycle where `out_valid` is low, `out_result` keeps the value of the most recent valid result. Operand values presented with `in_valid` low have no effect on any later output.
- R7: While `rst_n` is low, and directly after it, `out_valid` is 0 and `out_result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand set on `in_a`, `in_x`, `in_y` is to be processed |
| in_a | input | N | Multiplicand, two's complement |
| in_x | input | N | Multiplier, two's complement |
| in_y | input | 2N | Addend, two's complement |
| out_valid | output | 1 | `out_result` carries a new result |
| out_result | output | 2N | `a*x+y` modulo `2^(2N)` |

## Verification
Several checks run on every clock inside the RTL. Each register stage must pass its valid flag on unchanged one cycle later. Stages must hold their data through idle cycles. The number of operand sets in flight must stay between zero and the latency. In the combinational build, each result is compared against a behavioural multiply-add of the previous cycle's operands.

In the pipelined build, only the bench's reference model can show arithmetic correctness end to end. The same applies to the sign corners, the modular wrap and the result order under back-to-back and bubbled traffic. That model tracks every cycle over directed corner operands and a long random stream.

// File: rtl/fma_pkg.sv
package fma_pkg;

   // Partial-product bit of one array cell: AND of the operand bits,
   // inverted where exactly one of them is a sign bit.
   function automatic logic cell_pp(input logic a_bit, input logic x_bit, input logic flip);
      return (a_bit & x_bit) ^ flip;
   endfunction

   // Cycles from in_valid to out_valid for a given build.
   function automatic int unsigned pipe_latency(input int unsigned n, input bit piped);
      return piped ? n + 1 : 1;
   endfunction

endpackage

// File: rtl/fma_csa_row.sv
module fma_csa_row #(
   parameter int unsigned N   = 8,
   parameter int unsigned ROW = 0
) (
   input  logic [2*N-1:0] sum_in,
   input  logic [2*N-1:0] carry_in,
   input  logic [N-1:0]   op_a,
   input  logic           x_bit,
   output logic [2*N-1:0] sum_out,
   output logic [2*N-1:0] carry_out
);
   localparam int unsigned W = 2 * N;

   logic [W-1:0] pp_w;
   logic [W-2:0] cy_w;

   for (genvar b = 0; b < W; b++) begin : g_cell
      if (b >= ROW && b < ROW + N) begin : g_pp
         localparam int unsigned IDX  = b - ROW;
         localparam bit          FLIP = (IDX == N - 1) != (ROW == N - 1);
         assign pp_w[b] = fma_pkg::cell_pp(op_a[IDX], x_bit, FLIP);
      end else begin : g_zero
         assign pp_w[b] = 1'b0;
      end

      assign sum_out[b] = sum_in[b] ^ carry_in[b] ^ pp_w[b];

      if (b < W - 1) begin : g_cy
         assign cy_w[b] = (sum_in[b] & carry_in[b]) | (sum_in[b] & pp_w[b]) |
                          (carry_in[b] & pp_w[b]);
      end
   end

   assign carry_out = {cy_w, 1'b0};

endmodule

// File: rtl/fma_stage.sv
module fma_stage #(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [DW-1:0] in_data,
   output logic          out_valid,
   output logic [DW-1:0] out_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_data <= in_data;
      end
   end

   // R4: each stage delays the valid flag by exactly one cycle
   assert_valid_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (out_valid == $past(in_valid)))
      else $error("stage valid flag not delayed by one cycle");

   // R6: data is frozen across a cycle that carried no valid set
   assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(in_valid)) |-> $stable(out_data))
      else $error("stage data changed without a valid set");

endmodule

// File: rtl/fma_cpa.sv
module fma_cpa #(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] op_s,
   input  logic [W-1:0] op_c,
   output logic [W-1:0] total
);
   logic [W-1:0] rip;

   assign rip[0] = 1'b0;

   for (genvar b = 0; b < W; b++) begin : g_bit
      assign total[b] = op_s[b] ^ op_c[b] ^ rip[b];
      if (b < W - 1) begin : g_rip
         assign rip[b+1] = (op_s[b] & op_c[b]) | (op_s[b] & rip[b]) | (op_c[b] & rip[b]);
      end
   end

endmodule

// File: rtl/fma_array_mac.sv
module fma_array_mac #(
   parameter int unsigned N        = 8,
   parameter bit          PIPELINE = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_valid,
   input  logic [N-1:0]   in_a,
   input  logic [N-1:0]   in_x,
   input  logic [2*N-1:0] in_y,
   output logic           out_valid,
   output logic [2*N-1:0] out_result
);
   localparam int unsigned W   = 2 * N;
   localparam int unsigned LW  = 2 * W + 2 * N;
   localparam int unsigned LAT = fma_pkg::pipe_latency(N, PIPELINE);
   localparam logic [W-1:0] SIGN_FIX = (W'(1) << N) | (W'(1) << (W - 1));

   if (N < 2 || N > 31) begin : g_bad_width
      $error("fma_array_mac: N must lie in 2..31");
   end

   logic [W-1:0] s_lane [0:N];
   logic [W-1:0] c_lane [0:N];
   logic [N-1:0] a_lane [0:N];
   logic [N-1:0] x_lane [0:N];
   logic         v_lane [0:N];

   assign s_lane[0] = in_y;
   assign c_lane[0] = SIGN_FIX;
   assign a_lane[0] = in_a;
   assign x_lane[0] = in_x;
   assign v_lane[0] = in_valid;

   for (genvar r = 0; r < N; r++) begin : g_row
      logic [W-1:0] row_s;
      logic [W-1:0] row_c;

      fma_csa_row #(.N(N), .ROW(r)) u_row (
         .sum_in   (s_lane[r]),
         .carry_in (c_lane[r]),
         .op_a     (a_lane[r]),
         .x_bit    (x_lane[r][r]),
         .sum_out  (row_s),
         .carry_out(row_c)
      );

      if (PIPELINE) begin : g_reg
         logic [LW-1:0] stage_q;
         fma_stage #(.DW(LW)) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (v_lane[r]),
            .in_data  ({row_s, row_c, a_lane[r], x_lane[r]}),
            .out_valid(v_lane[r+1]),
            .out_data (stage_q)
         );
         assign {s_lane[r+1], c_lane[r+1], a_lane[r+1], x_lane[r+1]} = stage_q;
      end else begin : g_wire
         assign s_lane[r+1] = row_s;
         assign c_lane[r+1] = row_c;
         assign a_lane[r+1] = a_lane[r];
         assign x_lane[r+1] = x_lane[r];
         assign v_lane[r+1] = v_lane[r];
      end
   end

   logic [W-1:0] cpa_sum;

   fma_cpa #(.W(W)) u_cpa (
      .op_s (s_lane[N]),
      .op_c (c_lane[N]),
      .total(cpa_sum)
   );

   fma_stage #(.DW(W)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (v_lane[N]),
      .in_data  (cpa_sum),
      .out_valid(out_valid),
      .out_data (out_result)
   );

   // Checker: number of operand sets between input and output
   int unsigned chk_inflight;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chk_inflight <= 0;
      else chk_inflight <= chk_inflight + (in_valid ? 1 : 0) - (out_valid ? 1 : 0);
   end

   // R5: at most one set per pipeline slot is ever outstanding
   assert_inflight_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      chk_inflight <= LAT)
      else $error("more sets in flight than pipeline slots");

   // R4: a result never appears without an accepted operand set
   assert_out_needs_in_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (chk_inflight != 0))
      else $error("out_valid without a pending operand set");

   if (!PIPELINE) begin : g_flat_chk
      logic [W-1:0] flat_ref;
      assign flat_ref = W'($signed({{N{in_a[N-1]}}, in_a}) * $signed({{N{in_x[N-1]}}, in_x}))
                        + in_y;
      // R1: combinational array agrees with a behavioural multiply-add
      assert_flat_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && out_valid) |-> (out_result == $past(flat_ref)))
         else $error("array result differs from a*x+y");
   end

endmodule

// File: tb/fma_array_mac_bench.sv
module fma_array_mac_bench;
   localparam int unsigned N        = 8;
   localparam bit          PIPELINE = 1'b1;
   localparam int unsigned W        = 2 * N;
   localparam int unsigned LAT      = PIPELINE ? N + 1 : 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [N-1:0] in_a = '0;
   logic [N-1:0] in_x = '0;
   logic [W-1:0] in_y = '0;
   logic         out_valid;
   logic [W-1:0] out_result;

   always #10 clk = ~clk;

   fma_array_mac #(.N(N), .PIPELINE(PIPELINE)) u_fma_array_mac (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_x(in_x),
      .in_y(in_y), .out_valid(out_valid), .out_result(out_result)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic         ev [LAT];
   logic [W-1:0] er [LAT];
   string        et [LAT];
   logic [W-1:0] last_res = '0;

   localparam logic [N-1:0] MINV = {1'b1, {(N-1){1'b0}}};
   localparam logic [N-1:0] MAXV = {1'b0, {(N-1){1'b1}}};
   localparam logic [W-1:0] YMAX = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] YMIN = {1'b1, {(W-1){1'b0}}};

   function automatic logic [W-1:0] model(input logic [N-1:0] a, input logic [N-1:0] x,
                                          input logic [W-1:0] y);
      longint p;
      p = longint'($signed(a)) * longint'($signed(x)) + longint'($signed(y));
      return W'(p);
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // Drive one cycle, advance the model at the edge, compare mid-cycle
   task automatic cycle(input bit v, input logic [N-1:0] a, input logic [N-1:0] x,
                        input logic [W-1:0] y, input string tag);
      in_valid = v; in_a = a; in_x = x; in_y = y;
      @(posedge clk);
      for (int i = LAT - 1; i > 0; i--) begin
         ev[i] = ev[i-1]; er[i] = er[i-1]; et[i] = et[i-1];
      end
      ev[0] = v; er[0] = model(a, x, y); et[0] = tag;
      @(negedge clk);
      check(out_valid === ev[LAT-1], "R4 valid timing", longint'(out_valid), longint'(ev[LAT-1]));
      if (ev[LAT-1]) begin
         check(out_result === er[LAT-1], et[LAT-1], longint'(out_result), longint'(er[LAT-1]));
         last_res = er[LAT-1];
      end else begin
         check(out_result === last_res, "R6 hold when idle", longint'(out_result),
               longint'(last_res));
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R4 watchdog: actual hung expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < LAT; i++) begin ev[i] = 1'b0; er[i] = '0; et[i] = ""; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R7: reset state
      check(out_valid === 1'b0, "R7 reset valid", longint'(out_valid), 0);
      check(out_result === '0, "R7 reset result", longint'(out_result), 0);
      rst_n = 1'b1;
      cycle(1'b0, '0, '0, '0, "idle");
      check(out_result === '0, "R7 result after reset", longint'(out_result), 0);

      // R2: most negative operands
      cycle(1'b1, MINV, MINV, '0, "R2 min*min");
      cycle(1'b1, MINV, MAXV, '0, "R2 min*max");
      cycle(1'b1, MAXV, MINV, W'(5), "R2 max*min+5");
      cycle(1'b1, MAXV, MAXV, '0, "R1 max*max");
      cycle(1'b1, '1, '1, '0, "R1 -1*-1");
      cycle(1'b1, '0, N'(37), W'(1234), "R1 zero product passes y");
      cycle(1'b1, N'(13), '1, W'(7), "R1 mixed sign");
      // R3: wrap-around
      cycle(1'b1, N'(1), N'(1), YMAX, "R3 positive wrap");
      cycle(1'b1, '1, N'(1), YMIN, "R3 negative wrap");
      cycle(1'b1, MINV, MINV, YMAX, "R3 min*min+ymax wrap");

      // R6: idle cycles carrying junk operands
      for (int k = 0; k < LAT + 2; k++)
         cycle(1'b0, N'($urandom), N'($urandom), W'($urandom), "R6 junk");

      // R6: alternating bubbles
      for (int k = 0; k < 20; k++)
         cycle(k[0], N'($urandom), N'($urandom), W'($urandom), "R6 bubbled stream");

      // R5: back-to-back stream, then random occupancy
      for (int k = 0; k < 60; k++)
         cycle(1'b1, N'($urandom), N'($urandom), W'($urandom), "R5 back-to-back");
      for (int k = 0; k < 300; k++)
         cycle(($urandom % 4) != 0, N'($urandom), N'($urandom), W'($urandom), "R1 random");

      for (int k = 0; k < LAT + 2; k++) cycle(1'b0, '0, '0, '0, "R6 drain");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule